// File: doc/BRIEF.md
# Scratchpad Readback Sequencer

This block answers a scratchpad read command. Once started, it returns one byte for each byte request. The bytes come in this order: the stored low target-address byte, the stored high target-address byte, the transfer status byte, and then the scratchpad contents. The contents begin at the offset held in the low bits of the stored address and run through the final scratchpad location.

The block keeps a running CRC16 over everything it sends. The CRC is cleared at start and is first fed the read command code AAh. After the last scratchpad byte the block sends the inverted CRC, low byte first. Every request after that is answered with FFh until the sequence is restarted or aborted.

The address bytes, the status byte and the scratchpad contents are read from the write controller's storage as they are held there. That includes any address bits that were forced to zero and any scratchpad bytes that differ from what the master wrote. The scratchpad is read through a combinational port: the block drives an offset, and the byte at that offset comes back in the same cycle. A bus reset drops the block back to idle and leaves all stored state alone. Bit-slot timing belongs to another block.

Top module: `scratchpad_reader`

## Requirements
- R1: After reset, `byte_vld_o` is 0 and `byte_o` is 00h, and requests made before any start produce no valid byte.
- R2: Each request accepted in an active sequence produces `byte_vld_o` high for exactly the next cycle, and `byte_vld_o` is never high in a cycle that does not follow a request.
- R3: The first three bytes after a start are `tgt_lo_i`, `tgt_hi_i` and `stat_i`, in that order, each passed through unchanged.
- R4: The next bytes are the scratchpad bytes from offset `tgt_lo_i[4:0]` (for the default 32-entry depth) up through offset 31, one per request. Before each of these requests `sp_addr_o` shows the offset being read, and each byte equals `sp_data_i` at that offset.
- R5: After offset 31, two bytes follow: the bitwise inverse of CRC bits [7:0] and then of bits [15:8]. The CRC uses polynomial x16+x15+x2+1 in reflected form (A001h), starts from 0000h, takes AAh and then every byte sent before it, and shifts each byte in LSB first.
- R6: Every request after the second CRC byte returns FFh.
- R7: A `bus_reset_i` pulse returns the block to idle. No valid byte follows that cycle or any later request until a new start.
- R8: A start during an active sequence restarts it from the low address byte, with the CRC cleared.
- R9: A starting offset of 31 yields exactly one scratchpad byte before the CRC bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset pulse; aborts the sequence |
| rd_start_i | input | 1 | One-cycle pulse: read command received |
| byte_req_i | input | 1 | Request for the next outgoing byte |
| tgt_lo_i | input | 8 | Stored low target-address byte |
| tgt_hi_i | input | 8 | Stored high target-address byte |
| stat_i | input | 8 | Stored transfer status byte |
| sp_addr_o | output | 5 | Scratchpad read offset |
| sp_data_i | input | 8 | Scratchpad byte at `sp_addr_o` |
| byte_vld_o | output | 1 | Outgoing byte valid (one-cycle pulse) |
| byte_o | output | 8 | Outgoing byte |

## Verification
The assertions assume three things about the inputs. A request never arrives in the same cycle as a start. The stored address, status byte and scratchpad contents stay unchanged while a sequence runs. A start arrives only with reset released. The bench follows these rules. It drives a start in its own cycle and then releases it. It loads the address and status inputs and the scratchpad model before each start and leaves them alone until the sequence ends. It sweeps every starting offset, with request spacings of zero to two idle cycles.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALO  = 3'd1,
    PH_AHI  = 3'd2,
    PH_STAT = 3'd3,
    PH_DATA = 3'd4,
    PH_CRCL = 3'd5,
    PH_CRCH = 3'd6,
    PH_FILL = 3'd7
  } phase_t;

  // Reflected CRC update, one byte shifted in LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic [7:0]  d,
                                             input logic [15:0] poly);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ poly;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/srb_crc.sv
module srb_crc #(
  parameter int          CRC_W    = 16,
  parameter logic [15:0] POLY     = 16'hA001,
  parameter logic [15:0] INIT     = 16'h0000,
  parameter logic [7:0]  CMD_CODE = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o
);
  import srb_pkg::*;

  localparam logic [15:0] SEEDED = crc16_step(INIT, CMD_CODE, POLY);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)        crc_q <= INIT;
    else if (clr_i) crc_q <= SEEDED;
    else if (upd_i) crc_q <= crc16_step(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !upd_i) |=> $stable(crc_q)); // R5

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_q == SEEDED)); // R8

endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl #(
  parameter int SP_DEPTH = 32,
  parameter int OFS_W    = $clog2(SP_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_reset_i,
  input  logic                start_i,
  input  logic                req_i,
  input  logic [OFS_W-1:0]    start_ofs_i,
  output srb_pkg::phase_t     phase_o,
  output logic [OFS_W-1:0]    ptr_o,
  output logic                accept_o
);
  import srb_pkg::*;

  localparam logic [OFS_W-1:0] LAST = OFS_W'(SP_DEPTH - 1);

  phase_t           phase_q;
  logic [OFS_W-1:0] ptr_q;
  logic             active;

  assign active   = (phase_q != PH_IDLE);
  assign accept_o = req_i && active && !bus_reset_i && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
    end else if (bus_reset_i) begin
      phase_q <= PH_IDLE;
    end else if (start_i) begin
      phase_q <= PH_ALO;
      ptr_q   <= start_ofs_i;
    end else if (accept_o) begin
      unique case (phase_q)
        PH_ALO:  phase_q <= PH_AHI;
        PH_AHI:  phase_q <= PH_STAT;
        PH_STAT: phase_q <= PH_DATA;
        PH_DATA: begin
          if (ptr_q == LAST) phase_q <= PH_CRCL;
          else               ptr_q   <= ptr_q + 1'b1;
        end
        PH_CRCL: phase_q <= PH_CRCH;
        PH_CRCH: phase_q <= PH_FILL;
        default: phase_q <= PH_FILL;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !bus_reset_i) |=> (phase_q == PH_ALO && ptr_q == $past(start_ofs_i))); // R8

  AST_DATA_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (accept_o && phase_q == PH_DATA && ptr_q != LAST) |=> (phase_q == PH_DATA && ptr_q == $past(ptr_q) + 1'b1)); // R4

  AST_CRC_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (accept_o && phase_q == PH_DATA && ptr_q == LAST) |=> (phase_q == PH_CRCL)); // R5

  AST_FILL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FILL && !bus_reset_i && !start_i) |=> (phase_q == PH_FILL)); // R6

  AST_BUSRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> (phase_q == PH_IDLE)); // R7

endmodule

// File: rtl/srb_out.sv
module srb_out #(
  parameter int         CRC_W     = 16,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  srb_pkg::phase_t  phase_i,
  input  logic             accept_i,
  input  logic [7:0]       tgt_lo_i,
  input  logic [7:0]       tgt_hi_i,
  input  logic [7:0]       stat_i,
  input  logic [7:0]       sp_data_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             feed_o,
  output logic [7:0]       feed_data_o,
  output logic             vld_o,
  output logic [7:0]       byte_o
);
  import srb_pkg::*;

  logic [7:0] sel;
  logic       covered;

  always_comb begin
    sel     = FILL_BYTE;
    covered = 1'b0;
    unique case (phase_i)
      PH_ALO:  begin sel = tgt_lo_i;    covered = 1'b1; end
      PH_AHI:  begin sel = tgt_hi_i;    covered = 1'b1; end
      PH_STAT: begin sel = stat_i;      covered = 1'b1; end
      PH_DATA: begin sel = sp_data_i;   covered = 1'b1; end
      PH_CRCL: sel = ~crc_i[7:0];
      PH_CRCH: sel = ~crc_i[15:8];
      default: sel = FILL_BYTE;
    endcase
  end

  assign feed_o      = accept_i && covered;
  assign feed_data_o = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o <= accept_i;
      if (accept_i) byte_o <= sel;
    end
  end

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !accept_i |=> $stable(byte_o)); // R2

endmodule

// File: rtl/scratchpad_reader.sv
module scratchpad_reader #(
  parameter int          SP_DEPTH  = 32,
  parameter int          OFS_W     = $clog2(SP_DEPTH),
  parameter logic [7:0]  CMD_CODE  = 8'hAA,
  parameter logic [15:0] CRC_POLY  = 16'hA001,
  parameter logic [7:0]  FILL_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset_i,
  input  logic             rd_start_i,
  input  logic             byte_req_i,
  input  logic [7:0]       tgt_lo_i,
  input  logic [7:0]       tgt_hi_i,
  input  logic [7:0]       stat_i,
  output logic [OFS_W-1:0] sp_addr_o,
  input  logic [7:0]       sp_data_i,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o
);
  import srb_pkg::*;

  localparam int CRC_W = 16;

  phase_t           phase;
  logic [OFS_W-1:0] ptr;
  logic             accept;
  logic             feed;
  logic [7:0]       feed_data;
  logic [CRC_W-1:0] crc;

  srb_ctrl #(.SP_DEPTH(SP_DEPTH), .OFS_W(OFS_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bus_reset_i (bus_reset_i),
    .start_i     (rd_start_i),
    .req_i       (byte_req_i),
    .start_ofs_i (tgt_lo_i[OFS_W-1:0]),
    .phase_o     (phase),
    .ptr_o       (ptr),
    .accept_o    (accept)
  );

  srb_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(16'h0000), .CMD_CODE(CMD_CODE)) u_crc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (rd_start_i),
    .upd_i  (feed),
    .data_i (feed_data),
    .crc_o  (crc)
  );

  srb_out #(.CRC_W(CRC_W), .FILL_BYTE(FILL_BYTE)) u_out (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase),
    .accept_i    (accept),
    .tgt_lo_i    (tgt_lo_i),
    .tgt_hi_i    (tgt_hi_i),
    .stat_i      (stat_i),
    .sp_data_i   (sp_data_i),
    .crc_i       (crc),
    .feed_o      (feed),
    .feed_data_o (feed_data),
    .vld_o       (byte_vld_o),
    .byte_o      (byte_o)
  );

  assign sp_addr_o = ptr;

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> $past(byte_req_i)); // R2

  AST_NO_VLD_AFTER_BUSRST: assert property (@(posedge clk) disable iff (rst)
    $past(bus_reset_i) |-> !byte_vld_o); // R7

  AST_FILL_VALUE: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_o && $past(phase) == PH_FILL) |-> (byte_o == FILL_BYTE)); // R6

  AST_FIRST_IS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_o && $past(phase) == PH_ALO) |-> (byte_o == $past(tgt_lo_i))); // R3

endmodule

// File: tb/scratchpad_reader_test.sv
module scratchpad_reader_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_reset = 1'b0;
  logic       start = 1'b0;
  logic       req = 1'b0;
  logic [7:0] tgt_lo = 8'h00;
  logic [7:0] tgt_hi = 8'h00;
  logic [7:0] stat = 8'h00;
  logic [4:0] sp_addr;
  logic [7:0] sp_data;
  logic       vld;
  logic [7:0] dout;
  logic [7:0] sp_mem [32];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sp_data = sp_mem[sp_addr];

  scratchpad_reader uut (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset), .rd_start_i(start),
    .byte_req_i(req), .tgt_lo_i(tgt_lo), .tgt_hi_i(tgt_hi), .stat_i(stat),
    .sp_addr_o(sp_addr), .sp_data_i(sp_data), .byte_vld_o(vld), .byte_o(dout)
  );

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request; sample at the next falling edge.
  task automatic get_byte(output logic v, output logic [7:0] b);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    v = vld;
    b = dout;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string tag, input int gap);
    logic v;
    logic [7:0] b;
    get_byte(v, b);
    check(v === 1'b1, tag, v, 1);
    check(b === exp, tag, b, exp);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(vld === 1'b0, "R2 idle gap", vld, 0);
    end
  endtask

  task automatic load(input int ofs, input int seed);
    tgt_lo = 8'((seed % 8) * 32 + ofs);
    tgt_hi = 8'((ofs * 7 + seed) & 8'h0F);
    stat   = 8'(ofs ^ 8'hA0);
    for (int i = 0; i < 32; i++) sp_mem[i] = 8'(i * 37 + seed * 11 + 5);
  endtask

  task automatic run_seq(input int ofs, input int gap);
    logic [15:0] crc;
    crc = crc_add(16'h0000, 8'hAA);
    pulse_start();
    expect_byte(tgt_lo, "R3 low addr", gap); crc = crc_add(crc, tgt_lo);
    expect_byte(tgt_hi, "R3 high addr", gap); crc = crc_add(crc, tgt_hi);
    expect_byte(stat, "R3 status", gap); crc = crc_add(crc, stat);
    for (int i = ofs; i < 32; i++) begin
      check(sp_addr === 5'(i), "R4 offset", sp_addr, i);
      expect_byte(sp_mem[i], "R4 data", gap);
      crc = crc_add(crc, sp_mem[i]);
    end
    expect_byte(~crc[7:0], "R5 crc low", gap);
    expect_byte(~crc[15:8], "R5 crc high", gap);
    for (int k = 0; k < 3; k++) expect_byte(8'hFF, "R6 fill", gap);
  endtask

  initial begin
    logic v;
    logic [7:0] b;
    for (int i = 0; i < 32; i++) sp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(vld === 1'b0, "R1 reset vld", vld, 0);
    check(dout === 8'h00, "R1 reset byte", dout, 0);
    get_byte(v, b);
    check(v === 1'b0, "R1 idle request", v, 0);

    for (int ofs = 0; ofs < 32; ofs++) begin
      load(ofs, ofs + 3);
      run_seq(ofs, ofs % 3);
    end

    // R9: a single data byte from the last offset
    load(31, 9);
    run_seq(31, 0);

    // R7: abort mid-sequence
    load(4, 2);
    pulse_start();
    for (int k = 0; k < 5; k++) get_byte(v, b);
    @(negedge clk) bus_reset = 1'b1;
    @(negedge clk) bus_reset = 1'b0;
    get_byte(v, b);
    check(v === 1'b0, "R7 after bus reset", v, 0);
    run_seq(4, 1);

    // R8: restart while active
    load(10, 5);
    pulse_start();
    for (int k = 0; k < 7; k++) get_byte(v, b);
    load(12, 6);
    run_seq(12, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule